// File: doc/BRIEF.md
# Erasable Byte-Wide Programmable Memory Emulator

This block is a clocked, synthesizable stand-in for a byte-wide read-only memory that can be programmed in the field and wiped back to all ones. A host drives an active-low chip select, an active-low read gate, an active-low program strobe, a flag that says the high programming supply is present, an address and a data byte. From these the block derives one of six operating modes: read, standby, output disable, program, program verify and program inhibit. The data bus is only driven when both active-low selects are low. Tri-state is replaced by a separate `dout_oe` flag, and `dout` reads as zero whenever that flag is low.

Programming can only clear bits. A stored byte becomes the old byte AND the presented byte, and only the `erase` input (or reset) turns zeros back into ones. The erase is a sweep that writes 8'hFF to one location per clock for `2**ADDR_W` cycles, with the outputs held off. Access delay is modelled in clock cycles. A program strobe that stays low too long is treated as a DC level: it raises a sticky fault, and no further byte is written until reset.

Modes (internal select `op_mode_t`): `M_STANDBY` (ce_n=1, vpp_hi=0), `M_OUT_OFF` (ce_n=0, oe_n=1, vpp_hi=0), `M_READ` (ce_n=0, oe_n=0, vpp_hi=0), `M_PROGRAM` (vpp_hi=1, ce_n=0, oe_n=1), `M_VERIFY` (vpp_hi=1, ce_n=0, oe_n=0), `M_INHIBIT` (vpp_hi=1, ce_n=1).

Array state machine: `S_SWEEP` goes to `S_RUN` when the sweep pointer reaches the last address. `S_RUN` goes to `S_SWEEP` on `erase`. Reset enters `S_SWEEP`.

Strobe state machine: `P_IDLE` goes to `P_PULSE` on a low strobe in `M_PROGRAM`. `P_PULSE` goes to `P_IDLE` on a commit (strobe back high) or an abort (mode left). `P_PULSE` goes to `P_FAULT` when the strobe is low on more than `PGM_MAX` edges. `P_FAULT` is left only by reset. During `S_SWEEP` the strobe machine is held in `P_IDLE`.

Top module: `otp_rom_emu`

## Requirements
- R1: In `M_READ` (ce_n=0, oe_n=0, vpp_hi=0) outside a sweep, `dout_oe` is 1 and `dout` equals the byte stored at `addr`.
- R2: With ce_n=1, `dout_oe` is 0 and `dout` is 8'h00 whatever the level of oe_n.
- R3: With ce_n=0, oe_n=1 and vpp_hi=0, `dout_oe` is 0.
- R4: Count the first rising edge that samples ce_n low with a new address as edge 0, with oe_n already low. `dout_valid` is 0 after edges 0 to T_ACC-1 and 1 after edge T_ACC.
- R5: With CE and the address settled for more than T_ACC edges, count the first edge that samples oe_n low as edge 0. `dout_valid` is 0 after edges 0 to T_OE-1 and 1 after edge T_OE.
- R6: A change of `addr` drops `dout_valid` to 0 at once, before the next edge.
- R7: In `M_PROGRAM`, a strobe held low on 1 to PGM_MAX rising edges is committed at the first edge that sees it high. The byte at `addr` then becomes old AND `din`.
- R8: Programming never turns a stored 0 into a 1. Presenting 8'hFF leaves the byte unchanged.
- R9: In `M_VERIFY` (vpp_hi=1, ce_n=0, oe_n=0), `dout_oe` is 1 and `dout` is the stored byte.
- R10: A strobe pulse with ce_n=1 (inhibit) or with vpp_hi=0 leaves the array unchanged.
- R11: A strobe low on more than PGM_MAX consecutive edges in `M_PROGRAM` sets `prog_fault`, which stays 1 until reset. While it is set, no byte is written.
- R12: After reset, or the edge that samples `erase` high, `dout_oe` is 0 for the 2**ADDR_W-cycle sweep. Afterwards every byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a sweep |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | High programming supply present |
| erase | input | 1 | Starts a full-array erase sweep |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte presented for programming |
| dout | output | 8 | Read data, zero when not enabled |
| dout_oe | output | 1 | Data bus is driven (stands in for tri-state) |
| dout_valid | output | 1 | Access delay has elapsed for current address |
| prog_fault | output | 1 | Sticky over-long strobe flag |

## Verification
The bench programs a byte with a pattern that has zeros in both nibbles, then with a mask that clears one nibble, then with all ones. A plain overwrite, an OR or a lost write each produce a different readback, so the three results tell these faults apart. The same strobe is then issued under chip deselect, without the supply flag, and held far past the limit. Only the first programming case may change the array, which separates the inhibit, supply and DC-level checks from one another. Timing is probed one cycle before and exactly at the expected edge, once for a CE-led access and once for an OE-led access. This distinguishes the long and short delays and catches off-by-one counters.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUT_OFF,
        M_READ,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT
    } op_mode_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_PULSE,
        P_FAULT
    } pgm_state_t;

    typedef enum logic {
        S_SWEEP,
        S_RUN
    } arr_state_t;

    localparam logic [7:0] BYTE_BLANK = 8'hFF;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     vpp_hi,
    output op_mode_t mode
);
    always_comb begin
        if (vpp_hi) begin
            if (ce_n)      mode = M_INHIBIT;
            else if (oe_n) mode = M_PROGRAM;
            else           mode = M_VERIFY;
        end else begin
            if (ce_n)      mode = M_STANDBY;
            else if (oe_n) mode = M_OUT_OFF;
            else           mode = M_READ;
        end
    end
endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
    parameter int ADDR_W = 10,
    parameter int T_ACC  = 4,
    parameter int T_OE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              out_en,
    output logic              data_valid
);
    localparam int CW = $clog2(T_ACC + 2);

    logic [ADDR_W-1:0] addr_q;
    logic              ce_q_n, oe_q_n;
    logic [CW-1:0]     acc_cnt, oe_cnt;
    logic              acc_clr, oe_clr;

    assign acc_clr = ce_n | ce_q_n | (addr != addr_q);
    assign oe_clr  = oe_n | oe_q_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            ce_q_n  <= 1'b1;
            oe_q_n  <= 1'b1;
            acc_cnt <= '0;
            oe_cnt  <= '0;
        end else begin
            addr_q <= addr;
            ce_q_n <= ce_n;
            oe_q_n <= oe_n;
            if (acc_clr)                   acc_cnt <= '0;
            else if (acc_cnt < CW'(T_ACC)) acc_cnt <= acc_cnt + 1'b1;
            if (oe_clr)                    oe_cnt <= '0;
            else if (oe_cnt < CW'(T_OE))   oe_cnt <= oe_cnt + 1'b1;
        end
    end

    assign data_valid = out_en && !acc_clr && !oe_clr &&
                        (acc_cnt >= CW'(T_ACC)) && (oe_cnt >= CW'(T_OE));

    assert_valid_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (!$past(ce_n) && addr == $past(addr)));
    assert_valid_oe_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !$past(oe_n));
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int PGM_MAX = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  op_mode_t mode,
    input  logic     pgm_n,
    input  logic     hold,
    output logic     wr_en,
    output logic     fault
);
    localparam int PW = $clog2(PGM_MAX + 1);

    pgm_state_t    state, state_nx;
    logic [PW-1:0] low_cnt, low_cnt_nx;
    logic          in_prog;

    assign in_prog = (mode == M_PROGRAM) && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= P_IDLE;
            low_cnt <= '0;
        end else begin
            state   <= state_nx;
            low_cnt <= low_cnt_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        low_cnt_nx = low_cnt;
        wr_en      = 1'b0;
        unique case (state)
            P_IDLE: begin
                if (in_prog && !pgm_n) begin
                    state_nx   = P_PULSE;
                    low_cnt_nx = PW'(1);
                end
            end
            P_PULSE: begin
                if (!in_prog) begin
                    state_nx = P_IDLE;
                end else if (pgm_n) begin
                    wr_en    = 1'b1;
                    state_nx = P_IDLE;
                end else if (low_cnt == PW'(PGM_MAX)) begin
                    state_nx = P_FAULT;
                end else begin
                    low_cnt_nx = low_cnt + 1'b1;
                end
            end
            P_FAULT: state_nx = P_FAULT;
            default: state_nx = P_IDLE;
        endcase
    end

    assign fault = (state == P_FAULT);

    assert_commit_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (pgm_n && !$past(pgm_n)));
    assert_write_needs_program_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (mode == M_PROGRAM));
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    assert_fault_blocks_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_en);
endmodule

// File: rtl/otp_rom_emu.sv
module otp_rom_emu
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int T_ACC   = 4,
    parameter int T_OE    = 2,
    parameter int PGM_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe,
    output logic              dout_valid,
    output logic              prog_fault
);
    localparam int DEPTH = 1 << ADDR_W;

    op_mode_t          mode;
    arr_state_t        state, state_nx;
    logic [ADDR_W-1:0] sweep_ptr, sweep_ptr_nx;
    logic              sweeping;
    logic              wr_en;
    logic [7:0]        mem [DEPTH];

    otp_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .mode   (mode)
    );

    otp_prog_ctrl #(.PGM_MAX(PGM_MAX)) u_pgm (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .pgm_n (pgm_n),
        .hold  (sweeping),
        .wr_en (wr_en),
        .fault (prog_fault)
    );

    otp_access_timer #(.ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_OE(T_OE)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .out_en     (dout_oe),
        .data_valid (dout_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_SWEEP;
            sweep_ptr <= '0;
        end else begin
            state     <= state_nx;
            sweep_ptr <= sweep_ptr_nx;
        end
    end

    always_comb begin
        state_nx     = state;
        sweep_ptr_nx = sweep_ptr;
        unique case (state)
            S_SWEEP: begin
                sweep_ptr_nx = sweep_ptr + 1'b1;
                if (sweep_ptr == ADDR_W'(DEPTH - 1)) state_nx = S_RUN;
            end
            S_RUN: begin
                if (erase) begin
                    state_nx     = S_SWEEP;
                    sweep_ptr_nx = '0;
                end
            end
            default: state_nx = S_SWEEP;
        endcase
    end

    assign sweeping = (state == S_SWEEP);

    always_ff @(posedge clk) begin
        if (sweeping)   mem[sweep_ptr] <= BYTE_BLANK;
        else if (wr_en) mem[addr]      <= mem[addr] & din;
    end

    always_comb begin
        dout_oe = !sweeping && ((mode == M_READ) || (mode == M_VERIFY));
        dout    = dout_oe ? mem[addr] : 8'h00;
    end

    assert_bus_needs_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!ce_n && !oe_n));
    assert_standby_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dout_oe && dout == 8'h00));
    assert_erase_dark_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (erase && !sweeping) |=> !dout_oe);
endmodule

// File: tb/test_otp_rom_emu.sv
module test_otp_rom_emu;
    localparam int ADDR_W  = 10;
    localparam int T_ACC   = 4;
    localparam int T_OE    = 2;
    localparam int PGM_MAX = 8;
    localparam int DEPTH   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, erase = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = 8'hFF;
    logic [7:0]        dout;
    logic              dout_oe, dout_valid, prog_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    otp_rom_emu #(.ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_OE(T_OE), .PGM_MAX(PGM_MAX)) i_otp_rom_emu (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .erase(erase), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid), .prog_fault(prog_fault)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, input logic vpp, output logic [7:0] d);
        @(negedge clk);
        vpp_hi = vpp; ce_n = 1'b0; oe_n = 1'b0; addr = a;
        repeat (T_ACC + 1) @(negedge clk);
        d = dout;
    endtask

    task automatic strobe(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                          input logic vpp, input logic ce, input int len);
        @(negedge clk);
        vpp_hi = vpp; ce_n = ce; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        pgm_n = 1'b0;
        repeat (len) @(negedge clk);
        pgm_n = 1'b1;
        repeat (2) @(negedge clk);
        vpp_hi = 1'b0;
    endtask

    task automatic t_reset_sweep;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        check("R12 reset sweep dark", {7'd0, dout_oe}, 8'd0);
        check("R11 fault clear at reset", {7'd0, prog_fault}, 8'd0);
        repeat (DEPTH + 2) @(negedge clk);
    endtask

    task automatic t_access_timing;
        logic [7:0] d;
        @(negedge clk);
        vpp_hi = 1'b0; ce_n = 1'b1; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b0; addr = 10'd7;
        repeat (T_ACC) @(negedge clk);
        check("R4 valid before T_ACC", {7'd0, dout_valid}, 8'd0);
        @(negedge clk);
        check("R4 valid at T_ACC", {7'd0, dout_valid}, 8'd1);
        check("R1 read blank byte", dout, 8'hFF);
        check("R1 bus enabled", {7'd0, dout_oe}, 8'd1);
        addr = 10'd8;
        #1;
        check("R6 address change drops valid", {7'd0, dout_valid}, 8'd0);
        oe_n = 1'b1;
        repeat (T_ACC + 3) @(negedge clk);
        oe_n = 1'b0;
        repeat (T_OE) @(negedge clk);
        check("R5 valid before T_OE", {7'd0, dout_valid}, 8'd0);
        @(negedge clk);
        check("R5 valid at T_OE", {7'd0, dout_valid}, 8'd1);
        read_byte(10'd9, 1'b0, d);
        check("R1 second address blank", d, 8'hFF);
    endtask

    task automatic t_gating;
        @(negedge clk);
        vpp_hi = 1'b0; ce_n = 1'b1; oe_n = 1'b0;
        #1;
        check("R2 standby oe low", {7'd0, dout_oe}, 8'd0);
        check("R2 standby data zero", dout, 8'h00);
        oe_n = 1'b1;
        #1;
        check("R2 standby oe high", {7'd0, dout_oe}, 8'd0);
        ce_n = 1'b0;
        #1;
        check("R3 output disable", {7'd0, dout_oe}, 8'd0);
    endtask

    task automatic t_program;
        logic [7:0] d;
        strobe(10'd3, 8'hA5, 1'b1, 1'b0, 3);
        read_byte(10'd3, 1'b0, d);
        check("R7 program A5", d, 8'hA5);
        strobe(10'd3, 8'h0F, 1'b1, 1'b0, 1);
        read_byte(10'd3, 1'b0, d);
        check("R7 AND with 0F", d, 8'h05);
        strobe(10'd3, 8'hFF, 1'b1, 1'b0, PGM_MAX);
        read_byte(10'd3, 1'b0, d);
        check("R8 ones do not restore", d, 8'h05);
        read_byte(10'd3, 1'b1, d);
        check("R9 verify data", d, 8'h05);
        check("R9 verify drives bus", {7'd0, dout_oe}, 8'd1);
        read_byte(10'd4, 1'b0, d);
        check("R7 neighbour untouched", d, 8'hFF);
    endtask

    task automatic t_inhibit;
        logic [7:0] d;
        strobe(10'd3, 8'h00, 1'b1, 1'b1, 3);
        read_byte(10'd3, 1'b0, d);
        check("R10 inhibited by ce high", d, 8'h05);
        strobe(10'd3, 8'h00, 1'b0, 1'b0, 3);
        read_byte(10'd3, 1'b0, d);
        check("R10 no supply no write", d, 8'h05);
    endtask

    task automatic t_erase;
        logic [7:0] d;
        @(negedge clk);
        vpp_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = 10'd3; erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        check("R12 erase sweep dark", {7'd0, dout_oe}, 8'd0);
        repeat (DEPTH + 2) @(negedge clk);
        read_byte(10'd3, 1'b0, d);
        check("R12 erased byte", d, 8'hFF);
    endtask

    task automatic t_dc_guard;
        logic [7:0] d;
        strobe(10'd20, 8'h00, 1'b1, 1'b0, PGM_MAX + 4);
        check("R11 fault set", {7'd0, prog_fault}, 8'd1);
        read_byte(10'd20, 1'b0, d);
        check("R11 long pulse writes nothing", d, 8'hFF);
        strobe(10'd21, 8'h00, 1'b1, 1'b0, 2);
        read_byte(10'd21, 1'b0, d);
        check("R11 no write after fault", d, 8'hFF);
        check("R11 fault sticky", {7'd0, prog_fault}, 8'd1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_sweep();
        t_access_timing();
        t_gating();
        t_program();
        t_inhibit();
        t_erase();
        t_dc_guard();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule